// File: doc/BRIEF.md
# MSI Coherent L1 Child Controller

This block is the coherence engine of a small first-level cache that sits below a single parent (a shared cache or home memory). It keeps one line per address of a small address space. Each line carries an MSI state (I, S or M, ordered M above S above I), one data word and a pending-upgrade field made of a valid bit and a 2-bit target state. The processor side offers loads and stores through a valid/ready request channel and gets load data or a store acknowledgement back on a valid/ready response channel.

A load hits in S or M and a store hits only in M. On a miss the controller records the state it needs, sends an upgrade request to the parent and leaves the processor request unaccepted, so later processor traffic waits behind it. The parent answers with an upgrade response, and may at any time ask the child to drop to a lower state. The child answers such a downgrade request with a downgrade response, carrying the data word when it leaves M, or silently consumes the request when its line is already low enough. A separate input lets the surrounding logic give up a line voluntarily, which produces an unsolicited downgrade response.

Only one rule takes effect per cycle. Parent messages win over voluntary downgrades, which win over processor requests. Both outgoing channels are one-entry registered slots that hold their message until it is taken.

Top module: `msi_child_ctrl`

## Requirements
- R1: After reset every line is in state I (encoding I=0, S=1, M=2) with no pending upgrade, and both outgoing channels (`tx_valid`, `cpu_rsp_valid`) are low.
- R2: A load (`cpu_req_store`=0) to a line in S or M is accepted in the cycle it is presented and, one cycle later, presents `cpu_rsp_ack`=0 with the line's data on `cpu_rsp_rdata`.
- R3: A store (`cpu_req_store`=1) is accepted only when the line is in M. It writes `cpu_req_wdata` into the line and, one cycle later, presents `cpu_rsp_ack`=1 with `cpu_rsp_rdata` zero.
- R4: A load to a line in I, or a store to a line in I or S, is not accepted. If no upgrade is pending on that line, the line records a pending upgrade and the block emits, one cycle later, a request (`tx_is_resp`=0) whose target state is S for a load and M for a store, with `tx_has_data`=0. While the upgrade is pending no further request is sent for that line.
- R5: An incoming response (`rx_is_resp`=1) is always accepted. It sets the line state to `rx_state`, writes `rx_data` into the line only if the line was in I, and clears the pending field when `rx_state` is at or above the recorded target.
- R6: An incoming downgrade request (`rx_is_resp`=0) to a line whose state is above `rx_state` is accepted when the parent slot can take a message. It emits a response (`tx_is_resp`=1) with target `rx_state`, `tx_has_data`=1 and the line data only if the line was in M (otherwise data zero), and the line takes state `rx_state`.
- R7: An incoming downgrade request to a line already at or below `rx_state` is accepted and produces no outgoing message and no change to the line.
- R8: A voluntary downgrade (`vol_valid`) to a line with no pending upgrade and a state above `vol_state` emits a response like R6. If the line is already at or below `vol_state`, it is accepted with no effect. While an upgrade is pending on the line, it is held (`vol_ready`=0).
- R9: In a cycle with a valid parent message, neither the voluntary input nor the processor request is accepted. In a cycle with a valid voluntary downgrade, no processor request is accepted.
- R10: A message on either outgoing channel stays valid with unchanged fields until it is taken (valid and ready high together). A slot can accept a new message in the cycle its old one is taken.
- R11: Every outgoing parent message carries the source `CHILD_ID` on `tx_src` and destination `PARENT_ID` on `tx_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request taken this cycle |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Line address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Processor response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_ack | output | 1 | 1 = store acknowledgement, 0 = load data |
| cpu_rsp_rdata | output | DATA_W | Load data (zero for an acknowledgement) |
| vol_valid | input | 1 | Voluntary downgrade wanted |
| vol_ready | output | 1 | Voluntary downgrade taken this cycle |
| vol_addr | input | ADDR_W | Line to downgrade |
| vol_state | input | 2 | State to drop to |
| tx_valid | output | 1 | Message toward the parent present |
| tx_ready | input | 1 | Parent takes the message |
| tx_is_resp | output | 1 | 1 = downgrade response, 0 = upgrade request |
| tx_src | output | ID_W | Sender identifier |
| tx_dst | output | ID_W | Receiver identifier |
| tx_addr | output | ADDR_W | Line address |
| tx_state | output | 2 | Target state |
| tx_has_data | output | 1 | Data word is meaningful |
| tx_data | output | DATA_W | Data word |
| rx_valid | input | 1 | Message from the parent present |
| rx_ready | output | 1 | Message from the parent taken this cycle |
| rx_is_resp | input | 1 | 1 = upgrade response, 0 = downgrade request |
| rx_addr | input | ADDR_W | Line address |
| rx_state | input | 2 | Granted or requested state |
| rx_data | input | DATA_W | Data word of an upgrade response |

## Verification
The case that matters most is a parent message arriving in the same cycle as a processor request or a voluntary downgrade. Only one rule fires, so the parent message must win and the other request must stay unaccepted until a later cycle. The bench provokes this in the directed part by driving an upgrade response while the missed load is still presented, and in the random part by letting parent traffic, voluntary downgrades and processor requests overlap freely under random back-pressure. A behavioural model judges every cycle: it predicts each ready signal before the edge and each outgoing message after it, so a lost priority shows up as a ready mismatch or as a message that should not have appeared.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
   // state order matters: a numerically larger code is a higher permission
   localparam logic [1:0] ST_I = 2'd0;
   localparam logic [1:0] ST_S = 2'd1;
   localparam logic [1:0] ST_M = 2'd2;

   typedef struct packed {
      logic       vld;
      logic [1:0] tgt;
   } pend_t;
endpackage

// File: rtl/msi_line_table.sv
`timescale 1ns/1ps
module msi_line_table #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   // port used by parent messages
   input  logic [ADDR_W-1:0]   pa_addr,
   output logic [1:0]          pa_st,
   output logic [DATA_W-1:0]   pa_data,
   output msi_pkg::pend_t      pa_pend,
   // port used by voluntary downgrades
   input  logic [ADDR_W-1:0]   va_addr,
   output logic [1:0]          va_st,
   output logic                va_pend_v,
   // port used by processor requests
   input  logic [ADDR_W-1:0]   ca_addr,
   output logic [1:0]          ca_st,
   output logic [DATA_W-1:0]   ca_data,
   output logic                ca_pend_v,
   // single write port
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic                wr_st_en,
   input  logic [1:0]          wr_st,
   input  logic                wr_data_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                wr_pend_en,
   input  msi_pkg::pend_t      wr_pend
);
   localparam int NUM_LINES = 1 << ADDR_W;

   logic [1:0]        st_q   [NUM_LINES];
   logic [DATA_W-1:0] data_q [NUM_LINES];
   msi_pkg::pend_t    pend_q [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit_w;
      assign hit_w = (wr_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[i]   <= msi_pkg::ST_I;
            data_q[i] <= '0;
            pend_q[i] <= '0;
         end else if (hit_w) begin
            if (wr_st_en)   st_q[i]   <= wr_st;
            if (wr_data_en) data_q[i] <= wr_data;
            if (wr_pend_en) pend_q[i] <= wr_pend;
         end
      end
   end

   always_comb begin
      pa_st     = st_q[pa_addr];
      pa_data   = data_q[pa_addr];
      pa_pend   = pend_q[pa_addr];
      va_st     = st_q[va_addr];
      va_pend_v = pend_q[va_addr].vld;
      ca_st     = st_q[ca_addr];
      ca_data   = data_q[ca_addr];
      ca_pend_v = pend_q[ca_addr].vld;
   end
endmodule

// File: rtl/msi_msg_slot.sv
`timescale 1ns/1ps
module msi_msg_slot #(
   parameter int WIDTH         = 8,
   parameter bit FREE_ON_READY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic             free,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   logic             vld_q;
   logic [WIDTH-1:0] dat_q;

   if (FREE_ON_READY) begin : g_pass
      assign free = !vld_q || out_ready;
   end else begin : g_strict
      assign free = !vld_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (push) begin
         vld_q <= 1'b1;
         dat_q <= push_data;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign out_valid = vld_q;
   assign out_data  = dat_q;
endmodule

// File: rtl/msi_rule_sched.sv
`timescale 1ns/1ps
module msi_rule_sched #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   // parent messages
   input  logic                rx_valid,
   input  logic                rx_is_resp,
   input  logic [ADDR_W-1:0]   rx_addr,
   input  logic [1:0]          rx_state,
   input  logic [DATA_W-1:0]   rx_data,
   output logic                rx_ready,
   input  logic [1:0]          pa_st,
   input  logic [DATA_W-1:0]   pa_data,
   input  msi_pkg::pend_t      pa_pend,
   // voluntary downgrades
   input  logic                vol_valid,
   input  logic [ADDR_W-1:0]   vol_addr,
   input  logic [1:0]          vol_state,
   output logic                vol_ready,
   input  logic [1:0]          va_st,
   input  logic                va_pend_v,
   // processor requests
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   input  logic [1:0]          ca_st,
   input  logic [DATA_W-1:0]   ca_data,
   input  logic                ca_pend_v,
   // slot status
   input  logic                tx_free,
   input  logic                rsp_free,
   // line table write
   output logic [ADDR_W-1:0]   wr_addr,
   output logic                wr_st_en,
   output logic [1:0]          wr_st,
   output logic                wr_data_en,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_pend_en,
   output msi_pkg::pend_t      wr_pend,
   // toward parent
   output logic                tx_push,
   output logic                tx_is_resp,
   output logic [ADDR_W-1:0]   tx_addr,
   output logic [1:0]          tx_state,
   output logic                tx_has_data,
   output logic [DATA_W-1:0]   tx_data,
   // toward processor
   output logic                rsp_push,
   output logic                rsp_ack,
   output logic [DATA_W-1:0]   rsp_rdata
);
   import msi_pkg::*;

   logic       cpu_hit;
   logic [1:0] cpu_need;

   assign cpu_need = req_store ? ST_M : ST_S;
   assign cpu_hit  = (ca_st >= cpu_need);

   always_comb begin
      rx_ready    = 1'b0;
      vol_ready   = 1'b0;
      req_ready   = 1'b0;
      wr_addr     = rx_addr;
      wr_st_en    = 1'b0;
      wr_st       = ST_I;
      wr_data_en  = 1'b0;
      wr_data     = rx_data;
      wr_pend_en  = 1'b0;
      wr_pend     = '0;
      tx_push     = 1'b0;
      tx_is_resp  = 1'b1;
      tx_addr     = rx_addr;
      tx_state    = ST_I;
      tx_has_data = 1'b0;
      tx_data     = '0;
      rsp_push    = 1'b0;
      rsp_ack     = 1'b0;
      rsp_rdata   = '0;

      if (rx_valid) begin
         wr_addr = rx_addr;
         tx_addr = rx_addr;
         if (rx_is_resp) begin
            // upgrade grant: always drained
            rx_ready   = 1'b1;
            wr_st_en   = 1'b1;
            wr_st      = rx_state;
            wr_data_en = (pa_st == ST_I);
            wr_pend_en = pa_pend.vld && (rx_state >= pa_pend.tgt);
         end else if (pa_st > rx_state) begin
            if (tx_free) begin
               rx_ready    = 1'b1;
               wr_st_en    = 1'b1;
               wr_st       = rx_state;
               tx_push     = 1'b1;
               tx_state    = rx_state;
               tx_has_data = (pa_st == ST_M);
               tx_data     = (pa_st == ST_M) ? pa_data : '0;
            end
         end else begin
            // already low enough: consume silently
            rx_ready = 1'b1;
         end
      end else if (vol_valid) begin
         wr_addr = vol_addr;
         tx_addr = vol_addr;
         if (!va_pend_v) begin
            if (va_st > vol_state) begin
               if (tx_free) begin
                  vol_ready   = 1'b1;
                  wr_st_en    = 1'b1;
                  wr_st       = vol_state;
                  tx_push     = 1'b1;
                  tx_state    = vol_state;
                  tx_has_data = (va_st == ST_M);
                  tx_data     = (va_st == ST_M) ? ca_data_for_vol() : '0;
               end
            end else begin
               vol_ready = 1'b1;
            end
         end
      end else if (req_valid) begin
         wr_addr = req_addr;
         tx_addr = req_addr;
         wr_data = req_wdata;
         if (cpu_hit) begin
            if (rsp_free) begin
               req_ready  = 1'b1;
               rsp_push   = 1'b1;
               rsp_ack    = req_store;
               rsp_rdata  = req_store ? '0 : ca_data;
               wr_data_en = req_store;
            end
         end else if (!ca_pend_v && tx_free) begin
            wr_pend_en = 1'b1;
            wr_pend    = '{vld: 1'b1, tgt: cpu_need};
            tx_push    = 1'b1;
            tx_is_resp = 1'b0;
            tx_state   = cpu_need;
         end
      end
   end

   // the voluntary path reads its data through the parent-side data port,
   // which the top steers to the voluntary address when no parent message is present
   function automatic logic [DATA_W-1:0] ca_data_for_vol();
      return pa_data;
   endfunction
endmodule

// File: rtl/msi_child_ctrl.sv
`timescale 1ns/1ps
module msi_child_ctrl #(
   parameter int ADDR_W        = 3,
   parameter int DATA_W        = 16,
   parameter int ID_W          = 2,
   parameter int CHILD_ID      = 1,
   parameter int PARENT_ID     = 0,
   parameter bit FREE_ON_READY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_store,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_rsp_valid,
   input  logic              cpu_rsp_ready,
   output logic              cpu_rsp_ack,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   input  logic              vol_valid,
   output logic              vol_ready,
   input  logic [ADDR_W-1:0] vol_addr,
   input  logic [1:0]        vol_state,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_is_resp,
   output logic [ID_W-1:0]   tx_src,
   output logic [ID_W-1:0]   tx_dst,
   output logic [ADDR_W-1:0] tx_addr,
   output logic [1:0]        tx_state,
   output logic              tx_has_data,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic              rx_is_resp,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [1:0]        rx_state,
   input  logic [DATA_W-1:0] rx_data
);
   localparam int TX_W  = 1 + ADDR_W + 2 + 1 + DATA_W;
   localparam int RSP_W = 1 + DATA_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("msi_child_ctrl: ADDR_W must lie in 1..8");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("msi_child_ctrl: DATA_W must be positive");
   end
   if (CHILD_ID == PARENT_ID || CHILD_ID >= (1 << ID_W) || PARENT_ID >= (1 << ID_W)) begin : g_bad_id
      $error("msi_child_ctrl: identifiers must differ and fit in ID_W");
   end

   logic [1:0]        pa_st, va_st, ca_st, wr_st;
   logic [DATA_W-1:0] pa_data, ca_data, wr_data;
   msi_pkg::pend_t    pa_pend, wr_pend;
   logic              va_pend_v, ca_pend_v;
   logic [ADDR_W-1:0] wr_addr, pa_addr;
   logic              wr_st_en, wr_data_en, wr_pend_en;
   logic              tx_free, rsp_free, tx_push, rsp_push;
   logic              s_is_resp, s_has_data, s_ack;
   logic [ADDR_W-1:0] s_addr;
   logic [1:0]        s_state;
   logic [DATA_W-1:0] s_data, s_rdata;

   // parent port follows the voluntary address when no parent message is present
   assign pa_addr = rx_valid ? rx_addr : vol_addr;

   msi_line_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
      .clk, .rst_n,
      .pa_addr, .pa_st, .pa_data, .pa_pend,
      .va_addr(vol_addr), .va_st, .va_pend_v,
      .ca_addr(cpu_req_addr), .ca_st, .ca_data, .ca_pend_v,
      .wr_addr, .wr_st_en, .wr_st, .wr_data_en, .wr_data, .wr_pend_en, .wr_pend
   );

   msi_rule_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sched (
      .rx_valid, .rx_is_resp, .rx_addr, .rx_state, .rx_data, .rx_ready,
      .pa_st, .pa_data, .pa_pend,
      .vol_valid, .vol_addr, .vol_state, .vol_ready, .va_st, .va_pend_v,
      .req_valid(cpu_req_valid), .req_store(cpu_req_store), .req_addr(cpu_req_addr),
      .req_wdata(cpu_req_wdata), .req_ready(cpu_req_ready),
      .ca_st, .ca_data, .ca_pend_v,
      .tx_free, .rsp_free,
      .wr_addr, .wr_st_en, .wr_st, .wr_data_en, .wr_data, .wr_pend_en, .wr_pend,
      .tx_push, .tx_is_resp(s_is_resp), .tx_addr(s_addr), .tx_state(s_state),
      .tx_has_data(s_has_data), .tx_data(s_data),
      .rsp_push, .rsp_ack(s_ack), .rsp_rdata(s_rdata)
   );

   msi_msg_slot #(.WIDTH(TX_W), .FREE_ON_READY(FREE_ON_READY)) u_tx_slot (
      .clk, .rst_n, .push(tx_push),
      .push_data({s_is_resp, s_addr, s_state, s_has_data, s_data}),
      .free(tx_free), .out_valid(tx_valid), .out_ready(tx_ready),
      .out_data({tx_is_resp, tx_addr, tx_state, tx_has_data, tx_data})
   );

   msi_msg_slot #(.WIDTH(RSP_W), .FREE_ON_READY(FREE_ON_READY)) u_rsp_slot (
      .clk, .rst_n, .push(rsp_push),
      .push_data({s_ack, s_rdata}),
      .free(rsp_free), .out_valid(cpu_rsp_valid), .out_ready(cpu_rsp_ready),
      .out_data({cpu_rsp_ack, cpu_rsp_rdata})
   );

   assign tx_src = ID_W'(CHILD_ID);
   assign tx_dst = ID_W'(PARENT_ID);
endmodule

// File: rtl/msi_child_ctrl_chk.sv
`timescale 1ns/1ps
module msi_child_ctrl_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_ready,
   input logic              cpu_rsp_valid,
   input logic              cpu_rsp_ready,
   input logic              cpu_rsp_ack,
   input logic [DATA_W-1:0] cpu_rsp_rdata,
   input logic              vol_valid,
   input logic              vol_ready,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_is_resp,
   input logic [ADDR_W-1:0] tx_addr,
   input logic [1:0]        tx_state,
   input logic              tx_has_data,
   input logic [DATA_W-1:0] tx_data,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              rx_is_resp
);
   assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid &&
      $stable({tx_is_resp, tx_addr, tx_state, tx_has_data, tx_data}));

   assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid &&
      $stable({cpu_rsp_ack, cpu_rsp_rdata}));

   assert_parent_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !cpu_req_ready && !vol_ready);

   assert_vol_before_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vol_valid |-> !cpu_req_ready);

   assert_ack_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid && cpu_rsp_ack |-> cpu_rsp_rdata == '0);

   assert_upgrade_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_is_resp |-> !tx_has_data && (tx_state == 2'd1 || tx_state == 2'd2));

   assert_downgrade_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_is_resp |-> tx_state != 2'd2 && tx_state != 2'd3);

   assert_empty_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_has_data |-> tx_data == '0);

   assert_grant_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_is_resp |-> rx_ready);
endmodule

bind msi_child_ctrl msi_child_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
   .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_ack(cpu_rsp_ack), .cpu_rsp_rdata(cpu_rsp_rdata),
   .vol_valid(vol_valid), .vol_ready(vol_ready),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_is_resp(tx_is_resp), .tx_addr(tx_addr),
   .tx_state(tx_state), .tx_has_data(tx_has_data), .tx_data(tx_data),
   .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_is_resp(rx_is_resp)
);

// File: tb/msi_child_ctrl_bench.sv
`timescale 1ns/1ps
module msi_child_ctrl_bench;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int NL = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req_valid = 0, cpu_req_store = 0, cpu_rsp_ready = 1;
   logic [AW-1:0] cpu_req_addr = '0, vol_addr = '0, rx_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0, rx_data = '0;
   logic vol_valid = 0, tx_ready = 1, rx_valid = 0, rx_is_resp = 0;
   logic [1:0] vol_state = '0, rx_state = '0;
   logic cpu_req_ready, cpu_rsp_valid, cpu_rsp_ack, vol_ready, tx_valid;
   logic tx_is_resp, tx_has_data, rx_ready;
   logic [DW-1:0] cpu_rsp_rdata, tx_data;
   logic [1:0] tx_src, tx_dst, tx_state;
   logic [AW-1:0] tx_addr;

   always #10 clk = ~clk;

   msi_child_ctrl u_msi_child_ctrl (.*);

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference model
   int            mst [NL];
   logic [DW-1:0] mdat[NL];
   bit            mpv [NL];
   int            mpt [NL];
   bit e_txv, e_rsv;
   logic [26:0] e_tx;
   logic [16:0] e_rs;
   bit e_rx_rdy, e_vol_rdy, e_req_rdy, t_push, r_push;
   logic [26:0] t_val;
   logic [16:0] r_val;
   int w_a, w_st, w_pv; bit w_st_en, w_d_en, w_pv_en;
   logic [DW-1:0] w_d;
   string tag;

   function automatic logic [26:0] txw(bit r, int a, int s, bit hd, logic [DW-1:0] d);
      return {r, 3'(a), 2'(s), hd, d, 2'd1, 2'd0};
   endfunction

   task automatic eval();
      bit tf, rf;
      int a, need;
      e_rx_rdy = 0; e_vol_rdy = 0; e_req_rdy = 0; t_push = 0; r_push = 0;
      w_st_en = 0; w_d_en = 0; w_pv_en = 0; w_a = 0; w_st = 0; w_pv = 0; w_d = '0;
      t_val = '0; r_val = '0; tag = "R10";
      tf = !e_txv || tx_ready;
      rf = !e_rsv || cpu_rsp_ready;
      if (rx_valid) begin
         a = int'(rx_addr); w_a = a;
         if (rx_is_resp) begin
            tag = "R5"; e_rx_rdy = 1; w_st_en = 1; w_st = int'(rx_state);
            if (mst[a] == 0) begin w_d_en = 1; w_d = rx_data; end
            if (mpv[a] && int'(rx_state) >= mpt[a]) begin w_pv_en = 1; w_pv = 0; end
         end else if (mst[a] > int'(rx_state)) begin
            tag = "R6";
            if (tf) begin
               e_rx_rdy = 1; w_st_en = 1; w_st = int'(rx_state); t_push = 1;
               t_val = txw(1, a, int'(rx_state), mst[a] == 2, (mst[a] == 2) ? mdat[a] : '0);
            end
         end else begin
            tag = "R7"; e_rx_rdy = 1;
         end
         if (cpu_req_valid || vol_valid) tag = {tag, " R9"};
      end else if (vol_valid) begin
         a = int'(vol_addr); w_a = a; tag = "R8";
         if (!mpv[a]) begin
            if (mst[a] > int'(vol_state)) begin
               if (tf) begin
                  e_vol_rdy = 1; w_st_en = 1; w_st = int'(vol_state); t_push = 1;
                  t_val = txw(1, a, int'(vol_state), mst[a] == 2, (mst[a] == 2) ? mdat[a] : '0);
               end
            end else e_vol_rdy = 1;
         end
         if (cpu_req_valid) tag = {tag, " R9"};
      end else if (cpu_req_valid) begin
         a = int'(cpu_req_addr); w_a = a;
         need = cpu_req_store ? 2 : 1;
         if (mst[a] >= need) begin
            tag = cpu_req_store ? "R3" : "R2";
            if (rf) begin
               e_req_rdy = 1; r_push = 1;
               r_val = {cpu_req_store, cpu_req_store ? 16'h0 : mdat[a]};
               if (cpu_req_store) begin w_d_en = 1; w_d = cpu_req_wdata; end
            end
         end else begin
            tag = "R4";
            if (!mpv[a] && tf) begin
               w_pv_en = 1; w_pv = 1; t_push = 1;
               t_val = txw(0, a, need, 0, '0);
               mpt[a] = need;
            end
         end
      end
   endtask

   task automatic commit();
      if (w_st_en) mst[w_a] = w_st;
      if (w_d_en) mdat[w_a] = w_d;
      if (w_pv_en) mpv[w_a] = (w_pv != 0);
      if (t_push) begin e_txv = 1; e_tx = t_val; end
      else if (tx_ready) e_txv = 0;
      if (r_push) begin e_rsv = 1; e_rs = r_val; end
      else if (cpu_rsp_ready) e_rsv = 0;
   endtask

   task automatic tick();
      #2;
      eval();
      chk(tag, "rx_ready", rx_ready, e_rx_rdy);
      chk(tag, "vol_ready", vol_ready, e_vol_rdy);
      chk(tag, "cpu_req_ready", cpu_req_ready, e_req_rdy);
      @(posedge clk);
      commit();
      @(negedge clk);
      chk(tag, "tx_valid", tx_valid, e_txv);
      if (e_txv)
         chk(tag, "tx_msg", {tx_is_resp, tx_addr, tx_state, tx_has_data, tx_data, tx_src, tx_dst}, e_tx);
      chk(tag, "cpu_rsp_valid", cpu_rsp_valid, e_rsv);
      if (e_rsv) chk(tag, "cpu_rsp", {cpu_rsp_ack, cpu_rsp_rdata}, e_rs);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic set_req(bit v, bit st, int a, logic [DW-1:0] d);
      cpu_req_valid = v; cpu_req_store = st; cpu_req_addr = AW'(a); cpu_req_wdata = d;
   endtask
   task automatic set_rx(bit v, bit r, int a, int s, logic [DW-1:0] d);
      rx_valid = v; rx_is_resp = r; rx_addr = AW'(a); rx_state = 2'(s); rx_data = d;
   endtask
   task automatic set_vol(bit v, int a, int s);
      vol_valid = v; vol_addr = AW'(a); vol_state = 2'(s);
   endtask

   task automatic finish_up();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin mst[i] = 0; mdat[i] = '0; mpv[i] = 0; mpt[i] = 0; end
      e_txv = 0; e_rsv = 0; e_tx = '0; e_rs = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1", "tx_valid after reset", tx_valid, 0);
      chk("R1", "cpu_rsp_valid after reset", cpu_rsp_valid, 0);

      // R4 load miss on an I line, then held
      set_req(1, 0, 1, '0);
      tick();
      chk("R4", "upgrade request to S", {tx_valid, tx_is_resp, tx_state}, {1'b1, 1'b0, 2'd1});
      chk("R11", "source and destination", {tx_src, tx_dst}, {2'd1, 2'd0});
      run(2);
      // R9 grant arrives while the load is still presented; R5 data written from I
      set_rx(1, 1, 1, 1, 16'hA1A1);
      tick();
      set_rx(0, 0, 0, 0, '0);
      run(2);
      set_req(0, 0, 0, '0);
      run(1);
      // R2 second load hit
      set_req(1, 0, 1, '0); run(1);
      chk("R2", "load data", cpu_rsp_rdata, 16'hA1A1);
      // R3 store on S misses toward M; grant data ignored since line was S
      set_req(1, 1, 1, 16'h5555); run(2);
      set_rx(1, 1, 1, 2, 16'hFFFF); tick();
      set_rx(1, 0, 1, 1, '0); tick();
      chk("R5", "downgrade carries old data", {tx_has_data, tx_data}, {1'b1, 16'hA1A1});
      set_rx(0, 0, 0, 0, '0);
      run(4);
      set_rx(1, 1, 1, 2, 16'h0); tick();
      set_rx(0, 0, 0, 0, '0); run(2);
      set_req(0, 0, 0, '0); run(1);
      // R6 / R7 parent downgrades
      set_rx(1, 0, 1, 1, '0); tick();
      chk("R6", "M to S response with data", {tx_is_resp, tx_has_data, tx_data}, {1'b1, 1'b1, 16'h5555});
      set_rx(1, 0, 1, 1, '0); tick();
      set_rx(1, 0, 1, 2, '0); tick();
      set_rx(1, 0, 1, 0, '0); tick();
      chk("R6", "S to I response without data", {tx_has_data, tx_state}, {1'b0, 2'd0});
      set_rx(1, 0, 1, 0, '0); tick();
      chk("R7", "satisfied downgrade dropped", rx_ready, 1);
      set_rx(0, 0, 0, 0, '0); run(2);
      // R8 voluntary downgrades on line 2
      set_req(1, 1, 2, 16'h7777); run(2);
      set_rx(1, 1, 2, 2, 16'h1234); tick();
      set_rx(0, 0, 0, 0, '0); run(2);
      set_req(0, 0, 0, '0);
      set_vol(1, 2, 1); tick();
      chk("R8", "voluntary M to S data", {tx_has_data, tx_data}, {1'b1, 16'h7777});
      tick(); tick();
      set_vol(1, 2, 0); tick();
      set_vol(0, 0, 0); run(1);
      // R8 held while an upgrade is pending
      set_req(1, 0, 3, '0); run(1);
      set_req(0, 0, 0, '0);
      set_vol(1, 3, 0); run(3);
      chk("R8", "held while pending", vol_ready, 0);
      set_rx(1, 1, 3, 1, 16'h3333); tick();
      set_rx(0, 0, 0, 0, '0); run(2);
      set_vol(0, 0, 0);
      // R10 back-pressure on both slots
      tx_ready = 0; cpu_rsp_ready = 0;
      set_req(1, 0, 5, '0); run(3);
      set_req(1, 0, 3, '0); run(1);
      tx_ready = 1; cpu_rsp_ready = 1; run(3);
      set_req(0, 0, 0, '0); run(1);

      // random mixed traffic, every cycle judged by the model
      for (int c = 0; c < 4000; c++) begin
         if (!cpu_req_valid || cpu_req_ready || $urandom_range(0, 15) == 0)
            set_req($urandom_range(0, 2) != 0, 1'($urandom_range(0, 1)), $urandom_range(0, NL - 1),
                    16'($urandom));
         if (!rx_valid || rx_ready || $urandom_range(0, 7) == 0)
            set_rx($urandom_range(0, 3) == 0, 1'($urandom_range(0, 1)), $urandom_range(0, NL - 1),
                   $urandom_range(0, 2), 16'($urandom));
         set_vol($urandom_range(0, 9) == 0, $urandom_range(0, NL - 1), $urandom_range(0, 1));
         tx_ready = $urandom_range(0, 3) != 0;
         cpu_rsp_ready = $urandom_range(0, 3) != 0;
         tick();
      end
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R10 watchdog actual=expired expected=finished");
         finish_up();
      end
   end
endmodule